// File: doc/BRIEF.md
# Flash Read Line Buffer with Sequential Prefetch

This block sits between host firmware reads and a serial flash read engine. The host presents one word read at a time. Each read is either answered from a local 64-byte line buffer or turned into a whole-line fetch from the flash engine. The flash engine is driven through a simple request/acknowledge pair. A request carries a line tag and stays up with that tag until a one-cycle acknowledge returns the full line.

A 2-bit policy input picks the behaviour:

| Code | Behaviour |
|------|-----------|
| `00` | Lines are kept after a demand fill, so later reads to the same line are answered from the buffer. |
| `01` | Pass-through. Every read costs exactly one flash fetch, and both buffers are emptied. |
| `10` | Caching plus prefetch. After each demand fill, the block fetches the next sequential line into a second buffer. A read that hits that line promotes it to the current line and starts the next prefetch. This mode suits long runs of short reads to consecutive addresses. |
| `11` | Illegal. It is treated as `00`, and a status flag is raised. |

A read that targets the line already being prefetched waits for that fetch. It does not issue a second one.

The controller is a five-state machine:

| State | Meaning | Transitions |
|-------|---------|-------------|
| IDLE | Nothing is outstanding. | Hit: stay. Second-buffer hit: promote and go to PREF under prefetch, otherwise stay. Miss: go to DEMAND. |
| DEMAND | A demand line fetch is in flight. | On acknowledge: go to PREF under prefetch, otherwise to IDLE. |
| PREF | A prefetch is in flight and the host is still served. | Acknowledge with no read: go to IDLE. Read to the in-flight line: go to PWAIT, or stay in PREF if the acknowledge arrives in the same cycle. Read to an unrelated line: go to PDROP, or straight to DEMAND if the acknowledge arrives in the same cycle. |
| PWAIT | A read waits for the in-flight prefetch. | On acknowledge: answer the read, then go to PREF or IDLE. |
| PDROP | An unrelated read waits for the prefetch to finish. | On acknowledge: discard the line and go to DEMAND. |

Top module: `flash_rdbuf`

## Requirements
- R1: After reset `rd_rdy`=1, `rd_vld`=0, `fl_req`=0, `pol_err`=0, and both buffers are empty.
- R2: A read to a line not held in a buffer raises `fl_req` with `fl_tag` = `rd_addr[23:6]` and holds `rd_rdy` low until `fl_ack`. Data appears with `rd_vld` in the cycle after the acknowledge, as word `rd_addr[5:2]` of the line, taken from `fl_line[32*i +: 32]`.
- R3: A read that hits the current line is answered with `rd_vld` one cycle after it is accepted, without any flash request.
- R4: Under policy `00`, a demand fill is kept valid, later reads to that line hit, and no prefetch is issued.
- R5: Under policy `01`, every read performs exactly one flash fetch. Both buffers are invalid one cycle after `01` is applied, so nothing cached earlier or during pass-through is reused.
- R6: Under policy `10`, in the cycle after a demand fill the block requests line tag+1 while `rd_rdy` stays high.
- R7: Under policy `10`, a read to a completed prefetched line is answered one cycle after acceptance. That line becomes current, and a prefetch of the following line starts.
- R8: A read to the line whose prefetch is in flight waits for that prefetch, and the line is fetched only once.
- R9: A read to an unrelated line during a prefetch waits until the prefetch finishes, then issues its own demand fetch.
- R10: Policy `11` behaves as `00` (no prefetch), and `pol_err` is 1 one cycle after `11` is applied.
- R11: While `fl_req` is high and not yet acknowledged, `fl_tag` does not change.
- R12: Every accepted read either responds in the next cycle or drops `rd_rdy` until it is answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol | input | 2 | Read policy: 00 cache, 01 pass-through, 10 cache+prefetch, 11 illegal |
| pol_err | output | 1 | Illegal policy seen (registered) |
| rd_req | input | 1 | Host read request, one cycle, only while rd_rdy |
| rd_addr | input | ADDR_W | Host byte address |
| rd_rdy | output | 1 | Block can accept a read |
| rd_vld | output | 1 | Read data valid (one cycle) |
| rd_data | output | WORD_W | Read data word |
| fl_req | output | 1 | Line fetch request to flash engine |
| fl_tag | output | ADDR_W-6 | Line tag of the requested fetch |
| fl_ack | input | 1 | Fetch complete, line on fl_line |
| fl_line | input | 512 | Fetched 64-byte line |

## Verification
A hit is due in the cycle right after the accepting edge. A miss is due in the cycle after the edge that samples `fl_ack`. The bench therefore measures each read's latency from its drive point: exactly one cycle for hits, more for misses. The flash model in the bench acknowledges after a fixed four-cycle latency and logs every fetched tag. From that log the bench verifies how many fetches were made, for which tags, and in what order, sampling only after the relevant acknowledge has been taken. Prefetch start and the absence of prefetch are read off `fl_req`/`fl_tag` in the cycle right after the response, when the new state is already visible.

// File: rtl/frb_pkg.sv
package frb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEMAND,
        ST_PREF,
        ST_PWAIT,
        ST_PDROP
    } frb_state_e;

    typedef enum logic [1:0] {
        SRC_CUR,
        SRC_NXT,
        SRC_FLASH
    } frb_src_e;

    localparam logic [1:0] POL_CACHE  = 2'b00;
    localparam logic [1:0] POL_BYPASS = 2'b01;
    localparam logic [1:0] POL_PREF   = 2'b10;
    localparam logic [1:0] POL_BAD    = 2'b11;
endpackage

// File: rtl/frb_policy.sv
module frb_policy
    import frb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pol,
    output logic       cache_en,
    output logic       pf_en,
    output logic       bypass,
    output logic       pol_err
);
    logic bad;

    always_comb begin
        cache_en = 1'b0;
        pf_en    = 1'b0;
        bypass   = 1'b0;
        bad      = 1'b0;
        unique case (pol)
            POL_CACHE:  cache_en = 1'b1;
            POL_BYPASS: bypass   = 1'b1;
            POL_PREF: begin
                cache_en = 1'b1;
                pf_en    = 1'b1;
            end
            POL_BAD: begin
                cache_en = 1'b1;
                bad      = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pol_err <= 1'b0;
        else        pol_err <= bad;
    end
endmodule

// File: rtl/frb_linebuf.sv
module frb_linebuf #(
    parameter int TAG_W  = 18,
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [LINE_W-1:0] ld_data,
    input  logic              inv,
    output logic              vld,
    output logic [TAG_W-1:0]  tag,
    output logic [LINE_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            tag <= '0;
        end else if (ld) begin
            vld <= 1'b1;
            tag <= ld_tag;
        end else if (inv) begin
            vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (ld) data <= ld_data;
    end
endmodule

// File: rtl/frb_fsm.sv
module frb_fsm
    import frb_pkg::*;
#(
    parameter int TAG_W = 18,
    parameter int WD_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cache_en,
    input  logic             pf_en,
    input  logic             rd_req,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [WD_W-1:0]  req_wd,
    input  logic             cur_vld,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             nxt_vld,
    input  logic [TAG_W-1:0] nxt_tag,
    input  logic             fl_ack,
    output logic             rd_rdy,
    output logic             fl_req,
    output logic [TAG_W-1:0] fl_tag,
    output logic             cur_ld,
    output logic             cur_src_nxt,
    output logic [TAG_W-1:0] cur_ld_tag,
    output logic             nxt_ld,
    output logic [TAG_W-1:0] nxt_ld_tag,
    output logic             nxt_inv,
    output logic             resp_fire,
    output frb_src_e         resp_src,
    output logic [WD_W-1:0]  resp_wd
);
    frb_state_e       state, state_d;
    logic [TAG_W-1:0] pend_tag, pf_tag, pf_val;
    logic [WD_W-1:0]  pend_wd;
    logic             cap, pf_set;
    logic             cur_hit, nxt_hit, pf_match;

    assign cur_hit  = cur_vld && (cur_tag == req_tag);
    assign nxt_hit  = nxt_vld && (nxt_tag == req_tag);
    assign pf_match = (req_tag == pf_tag);
    assign nxt_ld_tag = pf_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend_tag <= '0;
            pend_wd  <= '0;
            pf_tag   <= '0;
        end else begin
            state <= state_d;
            if (cap) begin
                pend_tag <= req_tag;
                pend_wd  <= req_wd;
            end
            if (pf_set) pf_tag <= pf_val;
        end
    end

    always_comb begin
        state_d     = state;
        rd_rdy      = 1'b0;
        fl_req      = 1'b0;
        fl_tag      = pf_tag;
        cur_ld      = 1'b0;
        cur_src_nxt = 1'b0;
        cur_ld_tag  = req_tag;
        nxt_ld      = 1'b0;
        nxt_inv     = 1'b0;
        resp_fire   = 1'b0;
        resp_src    = SRC_CUR;
        resp_wd     = req_wd;
        cap         = 1'b0;
        pf_set      = 1'b0;
        pf_val      = pf_tag + 1'b1;
        unique case (state)
            ST_IDLE: begin
                rd_rdy = 1'b1;
                if (rd_req) begin
                    if (cur_hit) begin
                        resp_fire = 1'b1;
                    end else if (nxt_hit) begin
                        resp_fire   = 1'b1;
                        resp_src    = SRC_NXT;
                        cur_ld      = 1'b1;
                        cur_src_nxt = 1'b1;
                        nxt_inv     = 1'b1;
                        if (pf_en) begin
                            pf_set  = 1'b1;
                            pf_val  = req_tag + 1'b1;
                            state_d = ST_PREF;
                        end
                    end else begin
                        cap     = 1'b1;
                        state_d = ST_DEMAND;
                    end
                end
            end
            ST_DEMAND: begin
                fl_req = 1'b1;
                fl_tag = pend_tag;
                if (fl_ack) begin
                    resp_fire  = 1'b1;
                    resp_src   = SRC_FLASH;
                    resp_wd    = pend_wd;
                    cur_ld     = cache_en;
                    cur_ld_tag = pend_tag;
                    nxt_inv    = 1'b1;
                    if (pf_en) begin
                        pf_set  = 1'b1;
                        pf_val  = pend_tag + 1'b1;
                        state_d = ST_PREF;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PREF: begin
                rd_rdy = 1'b1;
                fl_req = 1'b1;
                nxt_ld = fl_ack && pf_en;
                if (rd_req && cur_hit) begin
                    resp_fire = 1'b1;
                    if (fl_ack) state_d = ST_IDLE;
                end else if (rd_req && pf_match) begin
                    if (fl_ack) begin
                        resp_fire  = 1'b1;
                        resp_src   = SRC_FLASH;
                        cur_ld     = cache_en;
                        cur_ld_tag = pf_tag;
                        nxt_ld     = 1'b0;
                        nxt_inv    = 1'b1;
                        if (pf_en) pf_set  = 1'b1;
                        else       state_d = ST_IDLE;
                    end else begin
                        cap     = 1'b1;
                        state_d = ST_PWAIT;
                    end
                end else if (rd_req) begin
                    cap     = 1'b1;
                    state_d = fl_ack ? ST_DEMAND : ST_PDROP;
                end else if (fl_ack) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PWAIT: begin
                fl_req = 1'b1;
                if (fl_ack) begin
                    resp_fire  = 1'b1;
                    resp_src   = SRC_FLASH;
                    resp_wd    = pend_wd;
                    cur_ld     = cache_en;
                    cur_ld_tag = pf_tag;
                    nxt_inv    = 1'b1;
                    if (pf_en) begin
                        pf_set  = 1'b1;
                        state_d = ST_PREF;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PDROP: begin
                fl_req = 1'b1;
                if (fl_ack) state_d = ST_DEMAND;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req && $stable(fl_tag)); // R11

    AST_WAIT_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PREF && rd_req && !cur_hit && pf_match && !fl_ack
        |=> state == ST_PWAIT && fl_tag == $past(fl_tag)); // R8

    AST_DROP_THEN_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PDROP && fl_ack |=> state == ST_DEMAND && fl_tag == $past(pend_tag)); // R9
endmodule

// File: rtl/flash_rdbuf.sv
module flash_rdbuf
    import frb_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LINE_BYTES = 64,
    parameter int WORD_W     = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [1:0]                           pol,
    output logic                                 pol_err,
    input  logic                                 rd_req,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic                                 rd_rdy,
    output logic                                 rd_vld,
    output logic [WORD_W-1:0]                    rd_data,
    output logic                                 fl_req,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] fl_tag,
    input  logic                                 fl_ack,
    input  logic [LINE_BYTES*8-1:0]              fl_line
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WD_W   = OFF_W - BYTE_W;

    logic              cache_en, pf_en, bypass;
    logic [TAG_W-1:0]  req_tag;
    logic [WD_W-1:0]   req_wd;
    logic              unused_lo;

    logic              cur_vld, nxt_vld;
    logic [TAG_W-1:0]  cur_tag, nxt_tag;
    logic [LINE_W-1:0] cur_data, nxt_data, cur_ld_data;

    logic              cur_ld, cur_src_nxt, nxt_ld, nxt_inv, resp_fire;
    logic [TAG_W-1:0]  cur_ld_tag, nxt_ld_tag;
    frb_src_e          resp_src;
    logic [WD_W-1:0]   resp_wd;
    logic [LINE_W-1:0] resp_line;

    assign req_tag   = rd_addr[ADDR_W-1:OFF_W];
    assign req_wd    = rd_addr[OFF_W-1:BYTE_W];
    assign unused_lo = ^rd_addr[BYTE_W-1:0];

    frb_policy u_pol (
        .clk(clk), .rst_n(rst_n), .pol(pol),
        .cache_en(cache_en), .pf_en(pf_en), .bypass(bypass), .pol_err(pol_err)
    );

    assign cur_ld_data = cur_src_nxt ? nxt_data : fl_line;

    frb_linebuf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_cur (
        .clk(clk), .rst_n(rst_n), .ld(cur_ld), .ld_tag(cur_ld_tag),
        .ld_data(cur_ld_data), .inv(bypass),
        .vld(cur_vld), .tag(cur_tag), .data(cur_data)
    );

    frb_linebuf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_nxt (
        .clk(clk), .rst_n(rst_n), .ld(nxt_ld), .ld_tag(nxt_ld_tag),
        .ld_data(fl_line), .inv(nxt_inv || bypass),
        .vld(nxt_vld), .tag(nxt_tag), .data(nxt_data)
    );

    frb_fsm #(.TAG_W(TAG_W), .WD_W(WD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .pf_en(pf_en),
        .rd_req(rd_req), .req_tag(req_tag), .req_wd(req_wd),
        .cur_vld(cur_vld), .cur_tag(cur_tag), .nxt_vld(nxt_vld), .nxt_tag(nxt_tag),
        .fl_ack(fl_ack), .rd_rdy(rd_rdy), .fl_req(fl_req), .fl_tag(fl_tag),
        .cur_ld(cur_ld), .cur_src_nxt(cur_src_nxt), .cur_ld_tag(cur_ld_tag),
        .nxt_ld(nxt_ld), .nxt_ld_tag(nxt_ld_tag), .nxt_inv(nxt_inv),
        .resp_fire(resp_fire), .resp_src(resp_src), .resp_wd(resp_wd)
    );

    always_comb begin
        unique case (resp_src)
            SRC_CUR:   resp_line = cur_data;
            SRC_NXT:   resp_line = nxt_data;
            SRC_FLASH: resp_line = fl_line;
            default:   resp_line = fl_line;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= resp_fire;
            if (resp_fire) rd_data <= resp_line[resp_wd*WORD_W +: WORD_W];
        end
    end

    AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pol == POL_BYPASS |=> !cur_vld && !nxt_vld); // R5

    AST_PF_NEEDS_POL: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_ld |-> pol == POL_PREF); // R6

    AST_BAD_POL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pol == POL_BAD |=> pol_err); // R10

    AST_ACCEPT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_rdy |=> rd_vld || !rd_rdy); // R12

    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_req && rd_req && rd_rdy && cur_vld && cur_tag == req_tag |=> rd_vld && !fl_req); // R3
endmodule

// File: tb/flash_rdbuf_test.sv
module flash_rdbuf_test;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   pol = 2'b00;
    logic         pol_err;
    logic         rd_req = 1'b0;
    logic [23:0]  rd_addr = '0;
    logic         rd_rdy, rd_vld;
    logic [31:0]  rd_data;
    logic         fl_req;
    logic [17:0]  fl_tag;
    logic         fl_ack = 1'b0;
    logic [511:0] fl_line = '0;

    int checks = 0, fails = 0, cyc = 0;
    int vld_cnt = 0, reads = 0, tag_err = 0, fcnt = 0;
    int ftag_q[$];
    logic [17:0] held;

    flash_rdbuf uut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] mkword(input int tag, input int w);
        return {tag[15:0] ^ 16'h5A5A, w[7:0], 8'hC3};
    endfunction

    function automatic logic [511:0] mkline(input int tag);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = mkword(tag, w);
        return l;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            summary();
        end
    end

    // flash engine model: fixed latency, one-cycle acknowledge
    always @(negedge clk) begin
        if (rd_vld) vld_cnt++;
        if (!rst_n) begin
            fl_ack = 1'b0; fcnt = 0;
        end else if (fl_ack) begin
            fl_ack = 1'b0; fcnt = 0;
        end else if (fl_req) begin
            if (fcnt > 0 && fl_tag != held) tag_err++;
            held = fl_tag;
            fcnt++;
            if (fcnt == LAT) begin
                fl_line = mkline(int'(fl_tag));
                fl_ack  = 1'b1;
                ftag_q.push_back(int'(fl_tag));
            end
        end else begin
            fcnt = 0;
        end
    end

    task automatic rd(input logic [23:0] a, output int lat, output logic [31:0] d);
        int g = 0;
        while (!rd_rdy && g < 500) begin @(negedge clk); g++; end
        rd_req = 1'b1; rd_addr = a;
        lat = cyc;
        @(negedge clk);
        rd_req = 1'b0;
        reads++;
        g = 0;
        while (!rd_vld && g < 500) begin @(negedge clk); g++; end
        lat = cyc - lat;
        d = rd_data;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int lat, n0, g;
        logic [31:0] d;
        wait_n(3);
        // R1 reset state
        chk("R1 rd_rdy", rd_rdy == 1'b1, rd_rdy, 1);
        chk("R1 rd_vld", rd_vld == 1'b0, rd_vld, 0);
        chk("R1 fl_req", fl_req == 1'b0, fl_req, 0);
        chk("R1 pol_err", pol_err == 1'b0, pol_err, 0);
        rst_n = 1'b1;
        wait_n(2);

        // policy 00: demand fill then hits
        pol = 2'b00;
        n0 = ftag_q.size();
        rd(24'h000104, lat, d);
        chk("R2 miss latency", lat > 1, lat, 2);
        chk("R2 miss data", d == mkword(4, 1), d, mkword(4, 1));
        chk("R2 fetch tag", ftag_q.size() == n0 + 1 && ftag_q[$] == 4, ftag_q[$], 4);
        rd(24'h00013C, lat, d);
        chk("R3 hit latency", lat == 1, lat, 1);
        chk("R4 hit data", d == mkword(4, 15), d, mkword(4, 15));
        chk("R3 hit no fetch", ftag_q.size() == n0 + 1, ftag_q.size(), n0 + 1);
        wait_n(3);
        chk("R4 no prefetch", fl_req == 1'b0, fl_req, 0);
        chk("R10 flag low on 00", pol_err == 1'b0, pol_err, 0);

        // policy 01: pass-through, invalidates
        pol = 2'b01;
        wait_n(2);
        n0 = ftag_q.size();
        rd(24'h000104, lat, d);
        chk("R5 invalidated miss", lat > 1, lat, 2);
        chk("R5 data", d == mkword(4, 1), d, mkword(4, 1));
        rd(24'h000108, lat, d);
        chk("R5 second miss", lat > 1, lat, 2);
        chk("R5 one fetch per read", ftag_q.size() == n0 + 2, ftag_q.size(), n0 + 2);
        pol = 2'b00;
        wait_n(2);
        rd(24'h000100, lat, d);
        chk("R5 nothing retained", lat > 1, lat, 2);
        rd(24'h000110, lat, d);
        chk("R4 refilled hit", lat == 1 && d == mkword(4, 4), d, mkword(4, 4));

        // policy 10: prefetch
        pol = 2'b10;
        wait_n(2);
        n0 = ftag_q.size();
        rd(24'h000800, lat, d);
        chk("R2 demand data", lat > 1 && d == mkword(32, 0), d, mkword(32, 0));
        chk("R6 prefetch tag", fl_req == 1'b1 && fl_tag == 18'h21, fl_tag, 18'h21);
        chk("R6 ready during prefetch", rd_rdy == 1'b1, rd_rdy, 1);
        g = 0;
        while (ftag_q.size() < n0 + 2 && g < 100) begin @(negedge clk); g++; end
        wait_n(2);
        rd(24'h000844, lat, d);
        chk("R7 promote hit latency", lat == 1, lat, 1);
        chk("R7 promote data", d == mkword(33, 1), d, mkword(33, 1));
        chk("R7 next prefetch", fl_req == 1'b1 && fl_tag == 18'h22, fl_tag, 18'h22);
        n0 = ftag_q.size();
        rd(24'h000888, lat, d);
        chk("R8 waits for prefetch", lat > 1, lat, 2);
        chk("R8 data", d == mkword(34, 2), d, mkword(34, 2));
        chk("R8 single fetch", ftag_q.size() == n0 + 1 && ftag_q[$] == 34, ftag_q.size(), n0 + 1);
        n0 = ftag_q.size();
        rd(24'h004010, lat, d);
        chk("R9 data", lat > 1 && d == mkword(256, 4), d, mkword(256, 4));
        chk("R9 order", ftag_q.size() == n0 + 2 && ftag_q[n0] == 35 && ftag_q[n0+1] == 256,
            ftag_q[$], 256);
        g = 0;
        while (fl_req && g < 100) begin @(negedge clk); g++; end

        // policy 11: behaves as 00 with flag
        pol = 2'b11;
        wait_n(2);
        chk("R10 flag", pol_err == 1'b1, pol_err, 1);
        rd(24'h008000, lat, d);
        chk("R10 miss data", lat > 1 && d == mkword(512, 0), d, mkword(512, 0));
        wait_n(6);
        chk("R10 no prefetch", fl_req == 1'b0, fl_req, 0);
        rd(24'h008020, lat, d);
        chk("R10 cached hit", lat == 1 && d == mkword(512, 8), d, mkword(512, 8));

        wait_n(2);
        chk("R11 tag held", tag_err == 0, tag_err, 0);
        chk("R12 one response per read", vld_cnt == reads, vld_cnt, reads);
        summary();
    end
endmodule